// File: doc/BRIEF.md
# Debug Event Action Resolver

This block sits beside a processor core's debug logic and decides what the core does when a debug event fires. Four debug modes can be enabled at the same time: external (a probe owns the core), internal (the core handles its own debug interrupts), wait (the core halts and waits for a probe), and trace (none of the others). The block settles which one governs each event using a fixed order of precedence. It then raises a stop request, a debug interrupt request or a trace pulse. Every event also produces a status-record strobe.

Wait mode needs two enables. One is a bit in the machine state that the block holds itself. The other is a level driven from the JTAG side. When the interrupt logic signals interrupt entry, the block saves the machine-state wait bit and clears it. Any of the return-from-interrupt strobes puts the saved value back. A stop request, once raised, stays high until a resume pulse arrives.

Top module: `debug_action_resolver`

## Requirements
- R1: In reset, and on the first cycle after it, stopReq, dbgIntReq, traceOut, statusRec and waitBit are all 0.
- R2: When waitWrEn is 1 and neither interrupt entry nor any return strobe is present, waitBit takes the value of waitWrVal on the next cycle.
- R3: An intEntry pulse saves the current waitBit and clears waitBit on the next cycle.
- R4: A pulse on any bit of intReturn, with no intEntry in the same cycle, loads waitBit with the value saved at the last entry on the next cycle.
- R5: If intEntry and an intReturn bit are both high in one cycle, the entry is performed and the return is ignored. waitBit reads 0 afterwards, and the saved value is the one held before that cycle.
- R6: An event with extDbgEn=1 sets stopReq on the next cycle. It raises neither dbgIntReq nor traceOut, whatever the other enables are.
- R7: An event with extDbgEn=0, intDbgEn=1 and dbgIntEn=1 gives a one-cycle dbgIntReq pulse on the next cycle. It does not set stopReq, even when wait mode is active.
- R8: Wait mode is active when waitBit=1 and jtagWaitEn=1. An event with wait mode active, extDbgEn=0, and intDbgEn=0 or dbgIntEn=0 sets stopReq on the next cycle.
- R9: An event with extDbgEn=0, intDbgEn=0 and wait mode inactive gives a one-cycle traceOut pulse on the next cycle. No stop and no interrupt follow.
- R10: Every event, in every mode, gives a one-cycle statusRec pulse on the next cycle.
- R11: stopReq stays 1 until a resume pulse and drops on the cycle after it. An event that sets stop in the same cycle as resume keeps stopReq at 1.
- R12: An event with intDbgEn=1, dbgIntEn=0, extDbgEn=0 and wait mode inactive gives only statusRec. There is no trace, stop or interrupt.
- R13: An event is resolved with the waitBit held at the start of its cycle. An intEntry in the same cycle does not change that event's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intDbgEn | input | 1 | Internal debug mode enable |
| extDbgEn | input | 1 | External debug mode enable |
| jtagWaitEn | input | 1 | Wait-mode enable from the JTAG side |
| dbgIntEn | input | 1 | Machine-state debug interrupt enable |
| waitWrEn | input | 1 | Write strobe for the machine-state wait bit |
| waitWrVal | input | 1 | Value written to the wait bit |
| intEntry | input | 1 | Interrupt entry pulse |
| intReturn | input | RET_KINDS | Return-from-interrupt pulses, one per variant |
| dbgEvent | input | 1 | Debug event pulse |
| resume | input | 1 | Pulse that releases stop state |
| stopReq | output | 1 | Stop state request, held |
| dbgIntReq | output | 1 | Debug interrupt request pulse |
| traceOut | output | 1 | Trace indication pulse |
| statusRec | output | 1 | Status-record strobe |
| waitBit | output | 1 | Current machine-state wait bit |

## Verification
Two pairs of functions can fall in the same cycle here. A debug event can coincide with an interrupt entry, which clears the wait bit the event depends on. A stop-setting event can coincide with a resume pulse. The bench drives each pair together on one cycle. A reference model computed from the requirements then predicts the result: the event must be resolved with the pre-entry wait bit, and stop must stay set. Entry and return strobes arriving together are provoked as well, and are judged by reading waitBit right after that cycle and again after a later return.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  // Strobes the control decoder issues to the state datapath each cycle
  typedef struct packed {
    logic setStop;
    logic clrStop;
    logic raiseInt;
    logic trace;
    logic record;
    logic saveWait;
    logic restoreWait;
    logic writeWait;
  } dbgStrobes_t;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_STOP  = 2'd1,
    ACT_INT   = 2'd2,
    ACT_TRACE = 2'd3
  } dbgAction_e;

endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
#(
  parameter int RET_KINDS = 3
) (
  input  logic                 intDbgEn,
  input  logic                 extDbgEn,
  input  logic                 jtagWaitEn,
  input  logic                 dbgIntEn,
  input  logic                 waitWrEn,
  input  logic                 intEntry,
  input  logic [RET_KINDS-1:0] intReturn,
  input  logic                 dbgEvent,
  input  logic                 resume,
  input  logic                 waitBitQ,
  output dbgStrobes_t          strobes
);

  logic       waitActive;
  logic       anyReturn;
  dbgAction_e action;

  assign waitActive = waitBitQ & jtagWaitEn;
  assign anyReturn  = |intReturn;

  // Fixed precedence: external, then internal with interrupts on, then wait, then trace
  always_comb begin
    if (extDbgEn)                action = ACT_STOP;
    else if (intDbgEn && dbgIntEn) action = ACT_INT;
    else if (waitActive)         action = ACT_STOP;
    else if (!intDbgEn)          action = ACT_TRACE;
    else                         action = ACT_NONE;
  end

  always_comb begin
    strobes             = '0;
    strobes.record      = dbgEvent;
    strobes.setStop     = dbgEvent && (action == ACT_STOP);
    strobes.raiseInt    = dbgEvent && (action == ACT_INT);
    strobes.trace       = dbgEvent && (action == ACT_TRACE);
    strobes.clrStop     = resume;
    // Entry outranks return, return outranks a plain write
    strobes.saveWait    = intEntry;
    strobes.restoreWait = !intEntry && anyReturn;
    strobes.writeWait   = !intEntry && !anyReturn && waitWrEn;
  end

endmodule

// File: rtl/dbg_datapath.sv
module dbg_datapath
  import dbg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dbgStrobes_t strobes,
  input  logic        waitWrVal,
  output logic        waitBitQ,
  output logic        stopQ,
  output logic        intQ,
  output logic        traceQ,
  output logic        recQ
);

  logic savedWaitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitBitQ   <= 1'b0;
      savedWaitQ <= 1'b0;
    end else if (strobes.saveWait) begin
      savedWaitQ <= waitBitQ;
      waitBitQ   <= 1'b0;
    end else if (strobes.restoreWait) begin
      waitBitQ   <= savedWaitQ;
    end else if (strobes.writeWait) begin
      waitBitQ   <= waitWrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ  <= 1'b0;
      intQ   <= 1'b0;
      traceQ <= 1'b0;
      recQ   <= 1'b0;
    end else begin
      if (strobes.setStop)      stopQ <= 1'b1;
      else if (strobes.clrStop) stopQ <= 1'b0;
      intQ   <= strobes.raiseInt;
      traceQ <= strobes.trace;
      recQ   <= strobes.record;
    end
  end

endmodule

// File: rtl/debug_action_resolver.sv
module debug_action_resolver
  import dbg_pkg::*;
#(
  parameter int RET_KINDS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intDbgEn,
  input  logic                 extDbgEn,
  input  logic                 jtagWaitEn,
  input  logic                 dbgIntEn,
  input  logic                 waitWrEn,
  input  logic                 waitWrVal,
  input  logic                 intEntry,
  input  logic [RET_KINDS-1:0] intReturn,
  input  logic                 dbgEvent,
  input  logic                 resume,
  output logic                 stopReq,
  output logic                 dbgIntReq,
  output logic                 traceOut,
  output logic                 statusRec,
  output logic                 waitBit
);

  dbgStrobes_t strobes;
  logic        waitBitQ;

  dbg_ctrl #(.RET_KINDS(RET_KINDS)) u_ctrl (
    .intDbgEn   (intDbgEn),
    .extDbgEn   (extDbgEn),
    .jtagWaitEn (jtagWaitEn),
    .dbgIntEn   (dbgIntEn),
    .waitWrEn   (waitWrEn),
    .intEntry   (intEntry),
    .intReturn  (intReturn),
    .dbgEvent   (dbgEvent),
    .resume     (resume),
    .waitBitQ   (waitBitQ),
    .strobes    (strobes)
  );

  dbg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .waitWrVal (waitWrVal),
    .waitBitQ  (waitBitQ),
    .stopQ     (stopReq),
    .intQ      (dbgIntReq),
    .traceQ    (traceOut),
    .recQ      (statusRec)
  );

  assign waitBit = waitBitQ;

endmodule

// File: rtl/dbg_resolver_chk.sv
module dbg_resolver_chk #(
  parameter int RET_KINDS = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intDbgEn,
  input logic                 extDbgEn,
  input logic                 dbgIntEn,
  input logic                 intEntry,
  input logic [RET_KINDS-1:0] intReturn,
  input logic                 dbgEvent,
  input logic                 resume,
  input logic                 stopReq,
  input logic                 dbgIntReq,
  input logic                 traceOut,
  input logic                 statusRec,
  input logic                 waitBit
);

  AST_EVENT_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    dbgEvent |=> statusRec); // R10

  AST_EXT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEvent && extDbgEn) |=> (stopReq && !dbgIntReq && !traceOut)); // R6

  AST_INT_NO_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEvent && !extDbgEn && intDbgEn && dbgIntEn && !stopReq && !resume)
      |=> (dbgIntReq && !stopReq)); // R7

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    intEntry |=> !waitBit); // R3

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !resume) |=> stopReq); // R11

  AST_TRACE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    traceOut |-> (!dbgIntReq && statusRec)); // R9

  AST_NO_SPURIOUS_REC: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEvent |=> !statusRec); // R10

endmodule

bind debug_action_resolver dbg_resolver_chk #(.RET_KINDS(RET_KINDS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .intDbgEn  (intDbgEn),
  .extDbgEn  (extDbgEn),
  .dbgIntEn  (dbgIntEn),
  .intEntry  (intEntry),
  .intReturn (intReturn),
  .dbgEvent  (dbgEvent),
  .resume    (resume),
  .stopReq   (stopReq),
  .dbgIntReq (dbgIntReq),
  .traceOut  (traceOut),
  .statusRec (statusRec),
  .waitBit   (waitBit)
);

// File: tb/sim_debug_action_resolver.sv
`timescale 1ns/1ps
module sim_debug_action_resolver;

  localparam int RET_KINDS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intDbgEn = 0, extDbgEn = 0, jtagWaitEn = 0, dbgIntEn = 0;
  logic waitWrEn = 0, waitWrVal = 0, intEntry = 0, dbgEvent = 0, resume = 0;
  logic [RET_KINDS-1:0] intReturn = '0;
  logic stopReq, dbgIntReq, traceOut, statusRec, waitBit;

  always #2.5 clk = ~clk;

  debug_action_resolver #(.RET_KINDS(RET_KINDS)) u0 (
    .clk(clk), .rstN(rstN), .intDbgEn(intDbgEn), .extDbgEn(extDbgEn),
    .jtagWaitEn(jtagWaitEn), .dbgIntEn(dbgIntEn), .waitWrEn(waitWrEn),
    .waitWrVal(waitWrVal), .intEntry(intEntry), .intReturn(intReturn),
    .dbgEvent(dbgEvent), .resume(resume), .stopReq(stopReq),
    .dbgIntReq(dbgIntReq), .traceOut(traceOut), .statusRec(statusRec),
    .waitBit(waitBit)
  );

  typedef struct {
    logic [4:0] exp;   // {stop, int, trace, rec, wait}
    string      tag;
  } item_t;

  item_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Reference model state
  logic mWait = 0, mSaved = 0, mStop = 0;

  function automatic logic [4:0] outs();
    return {stopReq, dbgIntReq, traceOut, statusRec, waitBit};
  endfunction

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b (stop,int,trace,rec,wait)", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted result
  task automatic step(input logic ext, input logic intd, input logic jw, input logic de,
                      input logic we, input logic wv, input logic ent,
                      input logic [RET_KINDS-1:0] ret, input logic ev, input logic res,
                      input string tag);
    item_t it;
    logic act, setS, pInt, pTr, nWait, nSaved;
    @(negedge clk);
    extDbgEn = ext; intDbgEn = intd; jtagWaitEn = jw; dbgIntEn = de;
    waitWrEn = we; waitWrVal = wv; intEntry = ent; intReturn = ret;
    dbgEvent = ev; resume = res;
    act = mWait && jw;
    setS = 0; pInt = 0; pTr = 0;
    if (ev) begin
      if (ext)            setS = 1;
      else if (intd && de) pInt = 1;
      else if (act)       setS = 1;
      else if (!intd)     pTr = 1;
    end
    nWait = mWait; nSaved = mSaved;
    if (ent) begin nSaved = mWait; nWait = 0; end
    else if (|ret) nWait = mSaved;
    else if (we) nWait = wv;
    mWait = nWait; mSaved = nSaved;
    if (setS) mStop = 1; else if (res) mStop = 0;
    it.exp = {mStop, pInt, pTr, ev, mWait};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 0, tag);
  endtask

  // Monitor: compares each result shortly after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(outs(), it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outs(), 5'b00000, "R1 in reset");
    rstN = 1;
    @(posedge clk); #1;
    check(outs(), 5'b00000, "R1 after reset");

    // R2 write the wait bit
    step(0, 0, 0, 0, 1, 1, 0, '0, 0, 0, "R2 write 1");
    // R9 trace mode: wait bit set but JTAG side off
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 0, "R9 trace");
    idle("R9 trace pulse ends");
    // R8 wait mode stop
    step(0, 0, 1, 0, 0, 0, 0, '0, 1, 0, "R8 wait stop");
    idle("R11 stop held");
    idle("R11 stop held 2");
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1, "R11 resume");
    // R7 internal with interrupts outranks wait
    step(0, 1, 1, 1, 0, 0, 0, '0, 1, 0, "R7 debug interrupt");
    idle("R7 pulse ends");
    // R8 internal but interrupts off: wait governs
    step(0, 1, 1, 0, 0, 0, 0, '0, 1, 0, "R8 int mode DE=0 stop");
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1, "R11 resume 2");
    // R12 internal mode, interrupts off, wait inactive
    step(0, 1, 0, 0, 0, 0, 0, '0, 1, 0, "R12 status only");
    // R6 external outranks everything
    step(1, 1, 1, 1, 0, 0, 0, '0, 1, 0, "R6 external");
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1, "R11 resume 3");
    // R3 entry clears and saves
    step(0, 0, 0, 0, 0, 0, 1, '0, 0, 0, "R3 entry");
    step(0, 0, 1, 0, 0, 0, 0, '0, 1, 0, "R3 wait off after entry -> trace");
    // R4 each return variant restores
    step(0, 0, 0, 0, 0, 0, 0, 3'b010, 0, 0, "R4 return variant 1");
    step(0, 0, 0, 0, 0, 0, 1, '0, 0, 0, "R3 entry again");
    step(0, 0, 0, 0, 0, 0, 0, 3'b100, 0, 0, "R4 return variant 2");
    // R5 entry and return together
    step(0, 0, 0, 0, 0, 0, 1, 3'b001, 0, 0, "R5 entry wins");
    step(0, 0, 0, 0, 0, 0, 0, 3'b001, 0, 0, "R5 saved kept");
    // R2 write ignored under return
    step(0, 0, 0, 0, 1, 0, 1, '0, 0, 0, "R2 entry beats write");
    step(0, 0, 0, 0, 1, 0, 0, 3'b001, 0, 0, "R2 return beats write");
    step(0, 0, 0, 0, 1, 0, 0, '0, 0, 0, "R2 write 0");
    step(0, 0, 0, 0, 0, 0, 1, '0, 0, 0, "R3 entry with bit 0");
    step(0, 0, 0, 0, 0, 0, 0, 3'b001, 0, 0, "R4 restore 0");
    step(0, 0, 0, 0, 1, 1, 0, '0, 0, 0, "R2 write 1 again");
    // R13 event together with entry uses pre-entry bit
    step(0, 0, 1, 0, 0, 0, 1, '0, 1, 0, "R13 event with entry stops");
    // R11 resume together with stop-setting event
    step(1, 0, 0, 0, 0, 0, 0, '0, 1, 1, "R11 set beats resume");
    step(0, 0, 0, 0, 0, 0, 0, '0, 0, 1, "R11 resume 4");
    // R10 record in every mode, back-to-back events
    step(0, 1, 0, 1, 0, 0, 0, '0, 1, 0, "R10 back to back 1");
    step(0, 0, 0, 0, 0, 0, 0, '0, 1, 0, "R10 back to back 2");
    idle("R10 no event no record");
    idle("drain");
    @(posedge clk); #2;
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        nFails++;
        nChecks++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule